// File: doc/BRIEF.md
# Interrupt Enable and Acceptance Controller

This block keeps the two interrupt enable flags of a small 8-bit-family processor core and decides, at each instruction boundary, whether an interrupt is taken. An instruction decoder feeds it one-cycle strobes: enable, disable, return-from-nonmaskable, end of instruction, and interrupt mode select. A level-sensitive maskable request and an edge-sensitive nonmaskable request come from the interrupt sources. The block returns a one-cycle accept pulse with a type bit, the current maskable interrupt mode, and the saved flag for the read path that copies it into the parity flag.

The primary flag gates maskable requests. The secondary flag saves the primary one while a nonmaskable handler runs, and the return-from-nonmaskable strobe puts it back. After an enable, one more whole instruction must complete before a maskable request can be taken. This lets a return placed straight after the enable finish first. Enable, disable and return strobes are expected in a cycle before the boundary strobe of their own instruction. Entry sequencing, stacking and vector fetch belong to other blocks.

Top module: `irq_enable_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `ief2_o` is 0, `irq_mode_o` is 0 and `accept_o` is 0. Maskable interrupts are disabled.
- R2: An `ei_i` strobe sets both flags to 1, and `ief2_o` reads 1 in the cycle after it.
- R3: A `di_i` strobe clears both flags to 0. A held maskable request is then never accepted.
- R4: A maskable accept happens only on a `bound_i` cycle when the primary flag is 1, `int_req_i` is high and no nonmaskable interrupt is pending. It is not taken on the first boundary after an enable. `accept_o` pulses one cycle after that boundary cycle, with `accept_nmi_o` at 0.
- R5: Accepting a maskable interrupt clears both flags.
- R6: A rising edge on `nmi_req_i` is latched until the next `bound_i` cycle. It is accepted there whatever the flags are, with `accept_o` and `accept_nmi_o` both pulsing 1.
- R7: On a nonmaskable accept, the secondary flag takes the old primary value and the primary flag is cleared.
- R8: A `retn_i` strobe copies the secondary flag into the primary flag.
- R9: `irq_mode_o` takes the value of `im_sel_i` (0, 1 or 2) on an `im_stb_i` strobe. The select value 3 leaves it unchanged.
- R10: When a nonmaskable interrupt is pending at the same boundary as an enabled maskable request, only the nonmaskable one is accepted. Each boundary gives at most one accept pulse.
- R11: A nonmaskable request held high gives exactly one acceptance. A new one needs the line to fall and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ei_i | input | 1 | Enable-interrupts instruction strobe |
| di_i | input | 1 | Disable-interrupts instruction strobe |
| retn_i | input | 1 | Return-from-nonmaskable strobe |
| bound_i | input | 1 | End-of-instruction strobe |
| im_stb_i | input | 1 | Interrupt mode load strobe |
| im_sel_i | input | 2 | Requested mode, 0 to 2 |
| int_req_i | input | 1 | Maskable request, level |
| nmi_req_i | input | 1 | Nonmaskable request, rising edge |
| accept_o | output | 1 | One-cycle accept pulse |
| accept_nmi_o | output | 1 | Accepted interrupt is nonmaskable |
| irq_mode_o | output | 2 | Current maskable interrupt mode |
| ief2_o | output | 1 | Secondary enable flag for the read path |

## Verification
The bench goes after the delay after an enable. A design without it would accept at the enable instruction's own boundary, before the following return could finish. It checks that a nonmaskable accept saves the primary flag into the secondary one. A design that simply cleared both would make the return-from-nonmaskable strobe leave interrupts off when they had been on. It also checks that a nonmaskable line held high is taken once, since a level-sensitive design would re-enter its handler at every boundary, and that a nonmaskable and a maskable request at the same boundary give one pulse of nonmaskable type. Finally it loads the reserved mode value, which a plain register would wrongly store.

// File: rtl/irq_ctrl_pkg.sv
// Shared widths and mode encoding for the interrupt enable controller.
package irq_ctrl_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_0    = 2'd0,
        MODE_1    = 2'd1,
        MODE_2    = 2'd2,
        MODE_RSVD = 2'd3
    } irq_mode_e;
endpackage

// File: rtl/irq_flag_pair.sv
// Holds the primary and secondary interrupt enable flags.
// Assumes at most one take strobe per cycle. Priority of updates within
// one cycle: nonmaskable take, maskable take, return, disable, enable.
module irq_flag_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic ei_i,
    input  logic di_i,
    input  logic retn_i,
    input  logic take_nmi_i,
    input  logic take_mask_i,
    output logic ief1_o,
    output logic ief2_o
);
    logic ief1_q, ief2_q;

    // Flag update with fixed priority among same-cycle events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ief1_q <= 1'b0;
            ief2_q <= 1'b0;
        end else if (take_nmi_i) begin
            ief2_q <= ief1_q;
            ief1_q <= 1'b0;
        end else if (take_mask_i) begin
            ief1_q <= 1'b0;
            ief2_q <= 1'b0;
        end else if (retn_i) begin
            ief1_q <= ief2_q;
        end else if (di_i) begin
            ief1_q <= 1'b0;
            ief2_q <= 1'b0;
        end else if (ei_i) begin
            ief1_q <= 1'b1;
            ief2_q <= 1'b1;
        end
    end

    assign ief1_o = ief1_q;
    assign ief2_o = ief2_q;

    AST_EI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_i && !di_i && !retn_i && !take_nmi_i && !take_mask_i) |=> (ief1_q && ief2_q)); // R2
    AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (di_i && !retn_i && !take_nmi_i && !take_mask_i) |=> (!ief1_q && !ief2_q)); // R3
    AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        take_mask_i |=> (!ief1_q && !ief2_q)); // R5
    AST_NMI_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi_i |=> (!ief1_q && ief2_q == $past(ief1_q))); // R7
    AST_RETN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (retn_i && !take_nmi_i && !take_mask_i) |=> (ief1_q == $past(ief2_q))); // R8
endmodule

// File: rtl/irq_mode_reg.sv
// Holds the maskable interrupt mode. Loads on a strobe and ignores the
// reserved select value.
module irq_mode_reg
    import irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              im_stb_i,
    input  logic [MODE_W-1:0] im_sel_i,
    output logic [MODE_W-1:0] mode_o
);
    irq_mode_e mode_q;

    // Mode register; the reserved select leaves it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_0;
        else if (im_stb_i && (im_sel_i != MODE_RSVD))
            mode_q <= irq_mode_e'(im_sel_i);
    end

    assign mode_o = mode_q;

    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (im_stb_i && im_sel_i == MODE_RSVD) |=> $stable(mode_q)); // R9
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != MODE_RSVD); // R9
endmodule

// File: rtl/irq_accept_arb.sv
// Decides acceptance at instruction boundaries. It latches a nonmaskable
// rising edge until it is taken, holds off maskable acceptance for one
// boundary after an enable, and gives the nonmaskable request priority.
// Assumes the primary flag comes from the flag pair, registered.
module irq_accept_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic bound_i,
    input  logic ei_i,
    input  logic int_req_i,
    input  logic nmi_req_i,
    input  logic ief1_i,
    output logic take_nmi_o,
    output logic take_mask_o,
    output logic accept_o,
    output logic accept_nmi_o
);
    logic nmi_prev_q, nmi_pend_q, hold_q;
    logic acc_q, acc_nmi_q;
    logic nmi_rise;

    assign nmi_rise    = nmi_req_i && !nmi_prev_q;
    assign take_nmi_o  = bound_i && nmi_pend_q;
    assign take_mask_o = bound_i && !nmi_pend_q && int_req_i && ief1_i && !hold_q;

    // Edge detector and pending latch for the nonmaskable request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_req_i;
            nmi_pend_q <= nmi_rise || (nmi_pend_q && !take_nmi_o);
        end
    end

    // One-boundary hold-off after an enable; a new enable wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else if (ei_i)
            hold_q <= 1'b1;
        else if (bound_i)
            hold_q <= 1'b0;
    end

    // Registered accept pulse and its type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= 1'b0;
            acc_nmi_q <= 1'b0;
        end else begin
            acc_q     <= take_nmi_o || take_mask_o;
            acc_nmi_q <= take_nmi_o;
        end
    end

    assign accept_o     = acc_q;
    assign accept_nmi_o = acc_nmi_q;

    AST_ACCEPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q |-> $past(bound_i)); // R4
    AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bound_i && nmi_pend_q) |=> (acc_q && acc_nmi_q)); // R6
    AST_TYPE_WITH_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_nmi_q |-> acc_q); // R10
    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({take_nmi_o, take_mask_o}) <= 1); // R10
    AST_NO_ACCEPT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !bound_i |=> !acc_q); // R4
endmodule

// File: rtl/irq_enable_ctrl.sv
// Top of the interrupt enable controller: the flag pair, the mode register
// and the boundary arbiter. Decoder strobes are one cycle wide.
module irq_enable_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              retn_i,
    input  logic              bound_i,
    input  logic              im_stb_i,
    input  logic [MODE_W-1:0] im_sel_i,
    input  logic              int_req_i,
    input  logic              nmi_req_i,
    output logic              accept_o,
    output logic              accept_nmi_o,
    output logic [MODE_W-1:0] irq_mode_o,
    output logic              ief2_o
);
    logic ief1, take_nmi, take_mask;

    irq_flag_pair u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .ei_i        (ei_i),
        .di_i        (di_i),
        .retn_i      (retn_i),
        .take_nmi_i  (take_nmi),
        .take_mask_i (take_mask),
        .ief1_o      (ief1),
        .ief2_o      (ief2_o)
    );

    irq_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .im_stb_i (im_stb_i),
        .im_sel_i (im_sel_i),
        .mode_o   (irq_mode_o)
    );

    irq_accept_arb u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .bound_i      (bound_i),
        .ei_i         (ei_i),
        .int_req_i    (int_req_i),
        .nmi_req_i    (nmi_req_i),
        .ief1_i       (ief1),
        .take_nmi_o   (take_nmi),
        .take_mask_o  (take_mask),
        .accept_o     (accept_o),
        .accept_nmi_o (accept_nmi_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!accept_o && !ief2_o && irq_mode_o == '0)); // R1
endmodule

// File: tb/irq_enable_ctrl_test.sv
module irq_enable_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ei = 0, di = 0, retn = 0, bnd = 0, ims = 0, intr = 0, nmi = 0;
    logic [1:0] sel = 0;
    logic acc, accn, ief2;
    logic [1:0] mode;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Reference model state
    bit m_f1, m_f2, m_hold, m_pend, m_prev, m_acc, m_accn;
    int m_mode;

    always #5 clk = ~clk;

    irq_enable_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ei_i(ei), .di_i(di), .retn_i(retn),
        .bound_i(bnd), .im_stb_i(ims), .im_sel_i(sel), .int_req_i(intr),
        .nmi_req_i(nmi), .accept_o(acc), .accept_nmi_o(accn),
        .irq_mode_o(mode), .ief2_o(ief2)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, updated at each rising edge.
    always @(posedge clk) begin
        bit tn, tm;
        if (!rst_n) begin
            m_f1 = 0; m_f2 = 0; m_hold = 0; m_pend = 0; m_prev = 0;
            m_acc = 0; m_accn = 0; m_mode = 0;
        end else begin
            tn = bnd && m_pend;
            tm = bnd && !m_pend && intr && m_f1 && !m_hold;
            m_acc = tn || tm;
            m_accn = tn;
            if (tn) begin m_f2 = m_f1; m_f1 = 0; end
            else if (tm) begin m_f1 = 0; m_f2 = 0; end
            else if (retn) m_f1 = m_f2;
            else if (di) begin m_f1 = 0; m_f2 = 0; end
            else if (ei) begin m_f1 = 1; m_f2 = 1; end
            if (ei) m_hold = 1; else if (bnd) m_hold = 0;
            m_pend = (nmi && !m_prev) || (m_pend && !tn);
            m_prev = nmi;
            if (ims && sel != 3) m_mode = sel;
        end
    end

    // Compare against the model every cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R4 accept", acc, m_acc);
            check("R6 type", accn, m_accn);
            check("R9 mode", mode, m_mode);
            check("R7 ief2", ief2, m_f2);
        end
    end

    // One decoder cycle; outputs are valid at the following falling edge.
    task automatic step(input bit e, input bit d, input bit r, input bit b,
                        input bit s, input logic [1:0] v);
        ei = e; di = d; retn = r; bnd = b; ims = s; sel = v;
        @(negedge clk);
        ei = 0; di = 0; retn = 0; bnd = 0; ims = 0; sel = 0;
    endtask

    task automatic boundary_expect(input string req, input int a, input int n);
        step(0, 0, 0, 1, 0, 0);
        check(req, acc, a);
        check(req, accn, n);
    endtask

    task automatic nmi_pulse();
        nmi = 1; @(negedge clk); nmi = 0; @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 ief2", ief2, 0); check("R1 mode", mode, 0); check("R1 accept", acc, 0);

        step(0, 0, 0, 0, 1, 1); check("R9 mode1", mode, 1);
        step(0, 0, 0, 0, 1, 3); check("R9 rsvd", mode, 1);
        step(0, 0, 0, 0, 1, 2); check("R9 mode2", mode, 2);
        step(0, 0, 0, 0, 1, 0); check("R9 mode0", mode, 0);

        intr = 1;
        boundary_expect("R3 disabled at reset", 0, 0);
        step(1, 0, 0, 0, 0, 0); check("R2 ief2", ief2, 1);
        boundary_expect("R4 delay after enable", 0, 0);
        boundary_expect("R4 maskable taken", 1, 0);
        check("R5 flags cleared", ief2, 0);
        boundary_expect("R5 no retake", 0, 0);

        step(1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 1, 0, 0, 0, 0); check("R3 ief2", ief2, 0);
        boundary_expect("R3 blocked", 0, 0);
        boundary_expect("R3 still blocked", 0, 0);

        intr = 0;
        step(1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        nmi_pulse();
        repeat (3) @(negedge clk);
        boundary_expect("R6 latched nmi", 1, 1);
        check("R7 saved flag", ief2, 1);
        intr = 1;
        boundary_expect("R7 primary cleared", 0, 0);
        step(0, 0, 1, 0, 0, 0);
        boundary_expect("R8 restored and taken", 1, 0);

        intr = 0;
        nmi_pulse();
        boundary_expect("R6 nmi while disabled", 1, 1);
        check("R7 saved zero", ief2, 0);

        step(1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        intr = 1;
        nmi = 1; @(negedge clk);
        boundary_expect("R10 nmi wins", 1, 1);
        boundary_expect("R10 single pulse", 0, 0);
        step(0, 0, 1, 0, 0, 0);
        intr = 0;
        boundary_expect("R11 held nmi once", 0, 0);
        boundary_expect("R11 held nmi again", 0, 0);
        nmi = 0; @(negedge clk);
        nmi = 1; @(negedge clk);
        boundary_expect("R11 new edge", 1, 1);
        nmi = 0;
        repeat (2) @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule